// File: doc/BRIEF.md
# Hash Message Input Buffer and Event Logic

This block is the front end of a memory-mapped hash accelerator. Software or a DMA engine writes the message one 32-bit word at a time into a 16-word buffer. Sixteen words make one 512-bit block. When the buffer completes a block, the block goes to an external compression core through a single-cycle start pulse, and the core answers with a done pulse when it finishes. The core captures the block on its start pulse, so the buffer can take the next block's words while the core is still working.

A final-digest request sends the remaining partial block to the core, marked as the last one and tagged with its word count. The block also holds the status flags, an interrupt mask, a registered interrupt line and a DMA request enable. The hardware clears that enable when the DMA engine signals the end of a transfer.

Top module: `hsh_feed_top`

## Requirements
- R1: After reset the word count, all status bits, the mask, the DMA enable, `irq`, `core_start` and `dma_req` are 0.
- R2: Each accepted data write raises the word count in `ctl_rdata[11:8]` by one. `ctl_rdata[12]` (not empty) is 1 exactly when that count is nonzero.
- R3: When the 16th word is accepted with the core idle, `core_start` is high for one cycle in the following cycle. In that cycle `core_last`=0 and `core_nwords`=16, the count is back to 0, and `core_blk[32*i+31:32*i]` holds the i-th word written (i = 0..15).
- R4: Busy (`stat_rdata[2]`) goes high with the start pulse and stays high through the cycle in which `core_done` is high. It falls at the edge that samples `core_done`.
- R5: A write that would complete a block while the core is busy is held: `din_wait`=1, the count stays at 15, and the word is taken once busy falls.
- R6: A pulse on `fin_go` issues a start with `core_last`=1 and `core_nwords` equal to the buffered count, two cycles later if the core is idle, otherwise after busy falls. Data writes wait until that start is issued.
- R7: The block-room status bit (`stat_rdata[0]`) sets whenever a block or a final partial block is handed to the core.
- R8: The digest status bit (`stat_rdata[1]`) sets when `core_done` ends a job that was marked last. It stays 0 after a full block.
- R9: A status write (`sts_wr`) clears each bit whose `sts_wdata` bit is 0 and leaves bits written with 1 unchanged. A hardware set in the same cycle wins over the clear.
- R10: `irq` is the OR of (mask AND status), registered, so it follows a mask or status change by one cycle. Mask bit 0 gates the block-room bit and mask bit 1 gates the digest bit.
- R11: A control write with `ctl_wdata[0]`=1 clears the count, the pending final request, busy and the digest bit. A `core_done` for a job started before it is ignored.
- R12: `ctl_wdata[1]` is written to the DMA enable (`ctl_rdata[1]`). `dma_req` = enable AND NOT `din_wait`. A `dma_end` pulse clears the enable. `stat_rdata[3]` = enable OR `dma_act`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din_wr | input | 1 | Data word write strobe |
| din_data | input | 32 | Message word |
| din_wait | output | 1 | Write held; keep strobe and data |
| fin_go | input | 1 | Request final digest of buffered words |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 2 | Bit 0 restart, bit 1 DMA enable |
| ctl_rdata | output | 32 | Bit 1 DMA enable, [11:8] word count, bit 12 not empty |
| sts_wr | input | 1 | Status write strobe (write 0 to clear) |
| sts_wdata | input | 2 | Bit 0 block room, bit 1 digest |
| stat_rdata | output | 4 | Room, digest, busy, DMA active |
| msk_wr | input | 1 | Mask write strobe |
| msk_wdata | input | 2 | Mask value |
| mask_rdata | output | 2 | Current mask |
| irq | output | 1 | Interrupt line |
| core_start | output | 1 | One-cycle block start |
| core_last | output | 1 | Started block is the final one |
| core_nwords | output | 5 | Valid words in started block |
| core_blk | output | 512 | Block contents, word i at [32i+31:32i] |
| core_done | input | 1 | Core finished current block |
| dma_req | output | 1 | DMA may write a word |
| dma_act | input | 1 | DMA transfer in progress |
| dma_end | input | 1 | DMA transfer finished |

## Verification
The bench sweeps every partial length from 1 to 15 words through the final path, checking the count after each write and the tagged word count and contents of the issued block. An off-by-one in the count or the index would give a wrong `core_nwords` or shifted block words. It holds a block-completing write against a long core latency to catch a design that drops or overwrites the held word. It also fires a status clear in the same cycle as a hand-off: a design that lets the clear win would lose the event. It restarts the block during a last job, so a design that does not discard the stale done would raise the digest bit. Busy length is measured against the core latency to find a flag that falls one cycle early or late.

// File: rtl/hsh_feed_pkg.sv
package hsh_feed_pkg;
  localparam int FEED_WORD_W = 32;
  localparam int FEED_DEPTH  = 16;
  localparam int ST_ROOM = 0;
  localparam int ST_DGST = 1;
  localparam int ST_BUSY = 2;
  localparam int ST_DMA  = 3;
  localparam int ST_W    = 4;
  localparam int EV_W    = 2;
endpackage

// File: rtl/hsh_word_store.sv
module hsh_word_store #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [CNT_W-1:0]        wr_idx,
  input  logic [WORD_W-1:0]       wr_data,
  output logic [WORD_W*DEPTH-1:0] blk_flat
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign blk_flat[g*WORD_W +: WORD_W] = mem[g];
  end
endmodule

// File: rtl/hsh_feed_ctrl.sv
module hsh_feed_ctrl #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH),
  localparam int NW_W  = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             din_wr,
  input  logic             fin_go,
  input  logic             core_done,
  output logic             din_wait,
  output logic             accept,
  output logic [CNT_W-1:0] cnt,
  output logic             busy,
  output logic             launch,
  output logic             dgst_evt,
  output logic             start,
  output logic             last,
  output logic [NW_W-1:0]  nwords
);
  localparam logic [CNT_W-1:0] TOP_IDX = CNT_W'(DEPTH - 1);
  localparam logic [NW_W-1:0]  FULL_NW = NW_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q;
  logic [NW_W-1:0]  nw_q;
  logic busy_q, fin_q, job_last_q, start_q, last_q;
  logic go_full, go_fin;

  assign din_wait = fin_q || (busy_q && cnt_q == TOP_IDX);
  assign accept   = din_wr && !din_wait && !init;
  assign go_full  = accept && cnt_q == TOP_IDX;
  assign go_fin   = fin_q && !busy_q && !init;
  assign launch   = go_full || go_fin;
  assign dgst_evt = core_done && busy_q && job_last_q && !init;

  always_ff @(posedge clk) begin
    if (rst || init) begin
      cnt_q      <= '0;
      nw_q       <= '0;
      busy_q     <= 1'b0;
      fin_q      <= 1'b0;
      job_last_q <= 1'b0;
      start_q    <= 1'b0;
      last_q     <= 1'b0;
    end else begin
      start_q <= launch;
      if (launch) begin
        last_q     <= go_fin;
        job_last_q <= go_fin;
        nw_q       <= go_fin ? {1'b0, cnt_q} : FULL_NW;
      end
      if (launch)      cnt_q <= '0;
      else if (accept) cnt_q <= cnt_q + 1'b1;
      if (launch)         busy_q <= 1'b1;
      else if (core_done) busy_q <= 1'b0;
      if (go_fin)      fin_q <= 1'b0;
      else if (fin_go) fin_q <= 1'b1;
    end
  end

  assign cnt    = cnt_q;
  assign busy   = busy_q;
  assign start  = start_q;
  assign last   = last_q;
  assign nwords = nw_q;

  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);
  assert_full_nwords_R3: assert property (@(posedge clk) disable iff (rst)
    (start_q && !last_q) |-> (nw_q == FULL_NW));
  assert_start_busy_R4: assert property (@(posedge clk) disable iff (rst)
    start_q |-> busy_q);
  assert_hold_word_R5: assert property (@(posedge clk) disable iff (rst)
    (din_wr && din_wait && !fin_q && !init) |=> (cnt_q == $past(cnt_q)));
  assert_restart_R11: assert property (@(posedge clk) disable iff (rst)
    init |=> (cnt_q == '0 && !busy_q && !fin_q));
endmodule

// File: rtl/hsh_event_regs.sv
module hsh_event_regs #(
  parameter int EV_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            init,
  input  logic [EV_W-1:0] set_evt,
  input  logic            sts_wr,
  input  logic [EV_W-1:0] sts_wdata,
  input  logic            msk_wr,
  input  logic [EV_W-1:0] msk_wdata,
  input  logic            dma_wr,
  input  logic            dma_wval,
  input  logic            dma_end,
  output logic [EV_W-1:0] sts,
  output logic [EV_W-1:0] mask,
  output logic            dma_en,
  output logic            irq
);
  logic [EV_W-1:0] sts_q, mask_q, keep;
  logic dma_en_q, irq_q;

  assign keep = sts_wr ? sts_wdata : '1;

  for (genvar b = 0; b < EV_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                   sts_q[b] <= 1'b0;
      else if (init && b == 1)   sts_q[b] <= 1'b0;
      else                       sts_q[b] <= (sts_q[b] & keep[b]) | set_evt[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      dma_en_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (msk_wr) mask_q <= msk_wdata;
      if (dma_end)     dma_en_q <= 1'b0;
      else if (dma_wr) dma_en_q <= dma_wval;
      irq_q <= |(mask_q & sts_q);
    end
  end

  assign sts    = sts_q;
  assign mask   = mask_q;
  assign dma_en = dma_en_q;
  assign irq    = irq_q;

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (set_evt[0] && sts_wr && !sts_wdata[0]) |=> sts_q[0]);
  assert_dgst_set_R8: assert property (@(posedge clk) disable iff (rst)
    set_evt[1] |=> sts_q[1]);
  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq_q);
  assert_dma_clear_R12: assert property (@(posedge clk) disable iff (rst)
    dma_end |=> !dma_en_q);
endmodule

// File: rtl/hsh_feed_top.sv
module hsh_feed_top
  import hsh_feed_pkg::*;
#(
  parameter int WORD_W = FEED_WORD_W,
  parameter int DEPTH  = FEED_DEPTH,
  localparam int CNT_W = $clog2(DEPTH),
  localparam int NW_W  = CNT_W + 1,
  localparam int BLK_W = WORD_W * DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din_wr,
  input  logic [WORD_W-1:0] din_data,
  output logic              din_wait,
  input  logic              fin_go,
  input  logic              ctl_wr,
  input  logic [1:0]        ctl_wdata,
  output logic [31:0]       ctl_rdata,
  input  logic              sts_wr,
  input  logic [EV_W-1:0]   sts_wdata,
  output logic [ST_W-1:0]   stat_rdata,
  input  logic              msk_wr,
  input  logic [EV_W-1:0]   msk_wdata,
  output logic [EV_W-1:0]   mask_rdata,
  output logic              irq,
  output logic              core_start,
  output logic              core_last,
  output logic [NW_W-1:0]   core_nwords,
  output logic [BLK_W-1:0]  core_blk,
  input  logic              core_done,
  output logic              dma_req,
  input  logic              dma_act,
  input  logic              dma_end
);
  logic init, accept, busy, launch, dgst_evt, dma_en;
  logic [CNT_W-1:0] cnt;
  logic [EV_W-1:0]  sts;

  assign init = ctl_wr && ctl_wdata[0];

  hsh_feed_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .init(init), .din_wr(din_wr), .fin_go(fin_go),
    .core_done(core_done), .din_wait(din_wait), .accept(accept), .cnt(cnt),
    .busy(busy), .launch(launch), .dgst_evt(dgst_evt), .start(core_start),
    .last(core_last), .nwords(core_nwords)
  );

  hsh_word_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(accept), .wr_idx(cnt), .wr_data(din_data),
    .blk_flat(core_blk)
  );

  hsh_event_regs #(.EV_W(EV_W)) u_ev (
    .clk(clk), .rst(rst), .init(init), .set_evt({dgst_evt, launch}),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .msk_wr(msk_wr),
    .msk_wdata(msk_wdata), .dma_wr(ctl_wr), .dma_wval(ctl_wdata[1]),
    .dma_end(dma_end), .sts(sts), .mask(mask_rdata), .dma_en(dma_en),
    .irq(irq)
  );

  always_comb begin
    stat_rdata          = '0;
    stat_rdata[ST_ROOM] = sts[0];
    stat_rdata[ST_DGST] = sts[1];
    stat_rdata[ST_BUSY] = busy;
    stat_rdata[ST_DMA]  = dma_en || dma_act;
    ctl_rdata             = '0;
    ctl_rdata[1]          = dma_en;
    ctl_rdata[8 +: CNT_W] = cnt;
    ctl_rdata[8 + CNT_W]  = (cnt != '0);
  end

  assign dma_req = dma_en && !din_wait;

  assert_req_gated_R12: assert property (@(posedge clk) disable iff (rst)
    din_wait |-> !dma_req);
endmodule

// File: tb/sim_hsh_feed_top.sv
module sim_hsh_feed_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din_wr = 0, fin_go = 0, ctl_wr = 0, sts_wr = 0, msk_wr = 0;
  logic [31:0] din_data = '0;
  logic [1:0] ctl_wdata = '0, sts_wdata = '0, msk_wdata = '0;
  logic core_done, dma_act = 0, dma_end = 0;
  logic din_wait, irq, core_start, core_last, dma_req;
  logic [31:0] ctl_rdata;
  logic [3:0] stat_rdata;
  logic [1:0] mask_rdata;
  logic [4:0] core_nwords;
  logic [511:0] core_blk;

  int checks = 0, errors = 0;
  int lat_cfg = 24;
  int lat_q = 0;

  always #10 clk = ~clk;

  hsh_feed_top u0 (
    .clk(clk), .rst(rst), .din_wr(din_wr), .din_data(din_data), .din_wait(din_wait),
    .fin_go(fin_go), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .stat_rdata(stat_rdata),
    .msk_wr(msk_wr), .msk_wdata(msk_wdata), .mask_rdata(mask_rdata), .irq(irq),
    .core_start(core_start), .core_last(core_last), .core_nwords(core_nwords),
    .core_blk(core_blk), .core_done(core_done), .dma_req(dma_req),
    .dma_act(dma_act), .dma_end(dma_end)
  );

  // fixed-latency core responder
  always @(posedge clk) begin
    if (rst) begin
      lat_q <= 0;
      core_done <= 1'b0;
    end else begin
      core_done <= (lat_q == 1);
      if (core_start) lat_q <= lat_cfg;
      else if (lat_q != 0) lat_q <= lat_q - 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int set, input int i);
    return {8'(set), 8'h5A, 16'(i * 7 + 3)};
  endfunction

  task automatic wr_word(input logic [31:0] d);
    din_wr = 1; din_data = d;
    while (din_wait) @(negedge clk);
    @(negedge clk);
    din_wr = 0;
  endtask

  task automatic ctl_put(input logic [1:0] v);
    ctl_wr = 1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic sts_put(input logic [1:0] v);
    sts_wr = 1; sts_wdata = v;
    @(negedge clk);
    sts_wr = 0;
  endtask

  task automatic wait_idle;
    while (stat_rdata[2] || lat_q != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k, n;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(ctl_rdata == 0, "R1 ctl", ctl_rdata, 0);
    chk(stat_rdata == 0, "R1 stat", stat_rdata, 0);
    chk(!irq && !core_start && !dma_req && mask_rdata == 0, "R1 outs",
        {irq, core_start, dma_req, mask_rdata}, 0);

    // R2, R6, R7, R8: final path over every partial length
    for (int len = 1; len < 16; len++) begin
      ctl_put(2'b01);
      sts_put(2'b00);
      for (int i = 0; i < len; i++) begin
        wr_word(pat(len, i));
        chk(ctl_rdata[11:8] == 4'(i + 1), "R2 count", ctl_rdata[11:8], i + 1);
        chk(ctl_rdata[12] == 1'b1, "R2 nempty", ctl_rdata[12], 1);
      end
      fin_go = 1;
      @(negedge clk);
      fin_go = 0;
      chk(!core_start, "R6 start early", core_start, 0);
      chk(din_wait, "R6 writes wait", din_wait, 1);
      @(negedge clk);
      chk(core_start && core_last, "R6 last start", {core_start, core_last}, 2'b11);
      chk(core_nwords == 5'(len), "R6 nwords", core_nwords, len);
      for (int i = 0; i < len; i++)
        chk(core_blk[32*i +: 32] == pat(len, i), "R6 word", core_blk[32*i +: 32], pat(len, i));
      chk(ctl_rdata[11:8] == 0 && !ctl_rdata[12], "R2 empty after", ctl_rdata[12:8], 0);
      chk(stat_rdata[0], "R7 room on final", stat_rdata[0], 1);
      wait_idle();
      chk(stat_rdata[1], "R8 digest set", stat_rdata[1], 1);
    end

    // R9 write-zero clear
    sts_put(2'b10);
    chk(stat_rdata[1:0] == 2'b10, "R9 clear bit0", stat_rdata[1:0], 2'b10);
    sts_put(2'b11);
    chk(stat_rdata[1:0] == 2'b10, "R9 ones keep", stat_rdata[1:0], 2'b10);
    sts_put(2'b01);
    chk(stat_rdata[1:0] == 2'b00, "R9 clear bit1", stat_rdata[1:0], 2'b00);

    // R3, R4, R7, R9 full block with a same-cycle clear
    ctl_put(2'b01);
    for (int i = 0; i < 15; i++) wr_word(pat(100, i));
    din_wr = 1; din_data = pat(100, 15); sts_wr = 1; sts_wdata = 2'b00;
    @(negedge clk);
    din_wr = 0; sts_wr = 0;
    chk(core_start && !core_last, "R3 start", {core_start, core_last}, 2'b10);
    chk(core_nwords == 16, "R3 nwords", core_nwords, 16);
    chk(ctl_rdata[11:8] == 0, "R3 count zero", ctl_rdata[11:8], 0);
    for (int i = 0; i < 16; i++)
      chk(core_blk[32*i +: 32] == pat(100, i), "R3 word", core_blk[32*i +: 32], pat(100, i));
    chk(stat_rdata[0], "R9 set wins", stat_rdata[0], 1);
    n = 1;
    @(negedge clk);
    chk(!core_start, "R3 one pulse", core_start, 0);
    while (stat_rdata[2]) begin n++; @(negedge clk); end
    chk(n == lat_cfg + 2, "R4 busy length", n, lat_cfg + 2);
    chk(!stat_rdata[1], "R8 no digest on full", stat_rdata[1], 0);

    // R10 interrupt gating
    msk_wr = 1; msk_wdata = 2'b01;
    @(negedge clk);
    msk_wr = 0;
    chk(!irq, "R10 lag", irq, 0);
    @(negedge clk);
    chk(irq, "R10 raised", irq, 1);
    msk_wr = 1; msk_wdata = 2'b10;
    @(negedge clk);
    msk_wr = 0;
    @(negedge clk);
    chk(!irq, "R10 masked", irq, 0);

    // R5, R12 stalled write with DMA enabled
    wait_idle();
    ctl_put(2'b01);
    ctl_put(2'b10);
    chk(ctl_rdata[1] && dma_req && stat_rdata[3], "R12 enable",
        {ctl_rdata[1], dma_req, stat_rdata[3]}, 3'b111);
    for (int i = 0; i < 16; i++) wr_word(pat(7, i));
    for (int i = 0; i < 15; i++) wr_word(pat(8, i));
    din_wr = 1; din_data = pat(8, 15);
    chk(din_wait, "R5 wait", din_wait, 1);
    chk(!dma_req, "R12 req gated", dma_req, 0);
    repeat (3) @(negedge clk);
    chk(ctl_rdata[11:8] == 15 && din_wait, "R5 held", ctl_rdata[11:8], 15);
    while (din_wait) @(negedge clk);
    @(negedge clk);
    din_wr = 0;
    chk(core_start && core_nwords == 16, "R5 accepted", {core_start, core_nwords}, 6'h30);
    chk(core_blk[32*15 +: 32] == pat(8, 15), "R5 held word", core_blk[32*15 +: 32], pat(8, 15));
    chk(core_blk[31:0] == pat(8, 0), "R5 first word", core_blk[31:0], pat(8, 0));
    dma_end = 1;
    @(negedge clk);
    dma_end = 0;
    chk(!ctl_rdata[1] && !dma_req && !stat_rdata[3], "R12 end clears",
        {ctl_rdata[1], dma_req, stat_rdata[3]}, 0);
    dma_act = 1;
    #1;
    chk(stat_rdata[3], "R12 active", stat_rdata[3], 1);
    dma_act = 0;
    wait_idle();

    // R11 restart during a last job
    ctl_put(2'b01);
    sts_put(2'b00);
    for (int i = 0; i < 3; i++) wr_word(pat(9, i));
    fin_go = 1;
    @(negedge clk);
    fin_go = 0;
    @(negedge clk);
    chk(core_start, "R11 job started", core_start, 1);
    ctl_put(2'b01);
    chk(!stat_rdata[2] && ctl_rdata[11:8] == 0, "R11 cleared", {stat_rdata[2], ctl_rdata[11:8]}, 0);
    k = lat_cfg + 4;
    repeat (k) @(negedge clk);
    chk(!stat_rdata[1] && !stat_rdata[2], "R11 stale done", stat_rdata[2:1], 0);
    wr_word(pat(9, 0));
    chk(ctl_rdata[11:8] == 1, "R11 fresh count", ctl_rdata[11:8], 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule